// File: doc/BRIEF.md
# Snoop-priority cache array arbiter

This block sits in front of a single-ported cache array that holds a tag, a data word and one parity bit per data byte for each index. Two requesters share it: the core, which issues loads, stores and castouts, and the bus snoop logic, which probes lines and pushes out data on a hit. Only one of them can reach the array in a given cycle. A snoop is never held back. A core request that meets a snoop in the same cycle is left waiting with its grant low and is accepted on a later clock.

Each read that returns live line data is checked for parity: a load hit, a castout of a valid line, and a snoop hit that pushes data. A mismatch raises a one-cycle machine-check pulse. The pulse comes with a sticky status field that names the kind of read that failed. Software clears that field by writing ones to it. Line valid bits are kept in flip-flops so that reset invalidates the whole array. Tag, data and parity sit in an inferred block RAM that reads the old contents before it writes.

Top module: `snoop_prio_array_arb`

## Requirements
- R1: If `snp_req` and `core_req` are both high in one cycle, `core_gnt` is low in that cycle. The snoop is accepted at the next edge, and its result appears one edge later, before any core result.
- R2: A waiting core requester keeps `core_req` and its fields stable. It is granted (`core_gnt` high) in the first cycle with `snp_req` low, which is the next cycle when the snoop lasts a single cycle.
- R3: A snoop that arrives in the cycle in which a waiting core access would otherwise be granted wins again, and the core access waits one more cycle.
- R4: A core load (`core_op` 0 or 3) gives `core_rvalid` one edge after the accepting edge. `core_hit` is high when the line is valid and its tag equals `core_tag`. `core_rdata` holds the stored word on a hit and zero on a miss.
- R5: A store (`core_op` 1) writes the tag and the data and marks the line valid. It writes one even parity bit per byte (the XOR of that byte's eight bits), inverted wherever the matching bit of `core_par_inj` is set. A store gives no read result.
- R6: A castout (`core_op` 2) returns the line's old data with `core_hit` equal to the old valid bit, whatever the tag. It leaves the line invalid.
- R7: A snoop gives `snp_rvalid` one edge after its request. `snp_hit` is valid and tag-equal, and `snp_rdata` is the push data on a hit or zero otherwise. A snoop never changes the array.
- R8: A parity mismatch on a load hit, a valid castout or a snoop hit makes `mchk` high for exactly the cycle of that result.
- R9: Misses and reads of invalid lines are never checked and never raise `mchk`.
- R10: The `mchk_src` bits are sticky. Bit 0 records a load hit, bit 1 a castout and bit 2 a snoop push. A bit is set in the same cycle as `mchk`.
- R11: Writing ones on `mchk_clr` clears the matching `mchk_src` bits at the next edge and leaves the others alone. A bit that is set and cleared in the same cycle stays set.
- R12: Synchronous reset invalidates every line and drives all result outputs, `mchk` and `mchk_src` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core access request, held until granted |
| core_op | input | 2 | 0 load, 1 store, 2 castout, 3 load |
| core_idx | input | IDX_W | Core line index |
| core_tag | input | TAG_W | Core tag to compare or write |
| core_wdata | input | DATA_W | Store data |
| core_par_inj | input | DATA_W/8 | Per-byte parity inversion applied on store |
| core_gnt | output | 1 | Core request accepted at this edge |
| core_rvalid | output | 1 | Load or castout result valid |
| core_hit | output | 1 | Load hit, or old valid bit for castout |
| core_rdata | output | DATA_W | Read data on hit, zero otherwise |
| snp_req | input | 1 | Snoop probe, always accepted |
| snp_idx | input | IDX_W | Snoop line index |
| snp_tag | input | TAG_W | Snoop tag |
| snp_rvalid | output | 1 | Snoop result valid |
| snp_hit | output | 1 | Snoop hit |
| snp_rdata | output | DATA_W | Push data on hit, zero otherwise |
| mchk | output | 1 | Machine-check request pulse |
| mchk_src | output | 3 | Sticky source: bit0 load hit, bit1 castout, bit2 snoop push |
| mchk_clr | input | 3 | Write-one-to-clear for `mchk_src` |

## Verification
A request is accepted at the edge where its grant (or snoop request) is high. Its result, together with any `mchk` pulse and the matching `mchk_src` bit, is registered at the following edge. The bench drives inputs on the falling edge, reads the combinational `core_gnt` just after that, and reads results two falling edges after the drive. For conflicts it counts one extra edge for each snoop that takes the port ahead of the core. The single-cycle pulse is confirmed one falling edge after each result, and the clear timing is tested by placing `mchk_clr` in the same cycle that a parity error is being registered.

// File: rtl/snoop_arb_pkg.sv
package snoop_arb_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_STORE,
    OP_CAST,
    OP_SNOOP
  } acc_op_e;

  localparam logic [1:0] CORE_STORE = 2'd1;
  localparam logic [1:0] CORE_CAST  = 2'd2;

  localparam int SRC_W    = 3;
  localparam int SRC_HIT  = 0;
  localparam int SRC_CAST = 1;
  localparam int SRC_PUSH = 2;

endpackage

// File: rtl/snoop_arb_par.sv
module snoop_arb_par #(
  parameter int BYTES = 4
) (
  input  logic [8*BYTES-1:0] data,
  output logic [BYTES-1:0]   par
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign par[b] = ^data[8*b +: 8];
  end
endmodule

// File: rtl/snoop_arb_ram.sv
module snoop_arb_ram #(
  parameter int AW = 4,
  parameter int DW = 44
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first single port: a castout sees the old line in its own cycle
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/snoop_arb_sel.sv
module snoop_arb_sel (
  input  logic clk,
  input  logic rst,
  input  logic core_req,
  input  logic snp_req,
  output logic core_gnt,
  output logic snp_win
);
  assign snp_win  = snp_req;
  assign core_gnt = core_req & ~snp_req;

  // a waiting core requester must keep asking until it is served
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (core_req && !core_gnt) |=> core_req);
endmodule

// File: rtl/snoop_prio_array_arb.sv
module snoop_prio_array_arb
  import snoop_arb_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  core_req,
  input  logic [1:0]            core_op,
  input  logic [IDX_W-1:0]      core_idx,
  input  logic [TAG_W-1:0]      core_tag,
  input  logic [DATA_W-1:0]     core_wdata,
  input  logic [DATA_W/8-1:0]   core_par_inj,
  output logic                  core_gnt,
  output logic                  core_rvalid,
  output logic                  core_hit,
  output logic [DATA_W-1:0]     core_rdata,
  input  logic                  snp_req,
  input  logic [IDX_W-1:0]      snp_idx,
  input  logic [TAG_W-1:0]      snp_tag,
  output logic                  snp_rvalid,
  output logic                  snp_hit,
  output logic [DATA_W-1:0]     snp_rdata,
  output logic                  mchk,
  output logic [SRC_W-1:0]      mchk_src,
  input  logic [SRC_W-1:0]      mchk_clr
);
  localparam int BYTES = DATA_W / 8;
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = TAG_W + DATA_W + BYTES;

  // ---------------- arbitration and array access ----------------
  logic sel_snp, sel_core;

  snoop_arb_sel u_sel (
    .clk      (clk),
    .rst      (rst),
    .core_req (core_req),
    .snp_req  (snp_req),
    .core_gnt (sel_core),
    .snp_win  (sel_snp)
  );
  assign core_gnt = sel_core;

  logic [IDX_W-1:0] acc_idx;
  logic [TAG_W-1:0] acc_tag;
  acc_op_e          acc_op;

  always_comb begin
    acc_idx = sel_snp ? snp_idx : core_idx;
    acc_tag = sel_snp ? snp_tag : core_tag;
    if (sel_snp)       acc_op = OP_SNOOP;
    else if (sel_core) begin
      case (core_op)
        CORE_STORE: acc_op = OP_STORE;
        CORE_CAST:  acc_op = OP_CAST;
        default:    acc_op = OP_LOAD;
      endcase
    end
    else               acc_op = OP_NONE;
  end

  logic [BYTES-1:0] wr_par;
  snoop_arb_par #(.BYTES(BYTES)) u_wr_par (.data(core_wdata), .par(wr_par));

  logic [ENT_W-1:0] ram_rdata;
  snoop_arb_ram #(.AW(IDX_W), .DW(ENT_W)) u_ram (
    .clk   (clk),
    .en    (sel_snp | sel_core),
    .we    (acc_op == OP_STORE),
    .addr  (acc_idx),
    .wdata ({core_tag, core_wdata, wr_par ^ core_par_inj}),
    .rdata (ram_rdata)
  );

  // valid bits in flops so reset can clear them
  logic [DEPTH-1:0] valid_q;
  acc_op_e          s1_op;
  logic [TAG_W-1:0] s1_tag;
  logic             s1_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      s1_op   <= OP_NONE;
      s1_tag  <= '0;
      s1_vld  <= 1'b0;
    end else begin
      s1_op  <= acc_op;
      s1_tag <= acc_tag;
      s1_vld <= valid_q[acc_idx];
      if (acc_op == OP_STORE)     valid_q[core_idx] <= 1'b1;
      else if (acc_op == OP_CAST) valid_q[core_idx] <= 1'b0;
    end
  end

  // ---------------- lookup, parity check, results ----------------
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic [BYTES-1:0]  rd_par, rd_par_calc;

  assign rd_tag  = ram_rdata[ENT_W-1 -: TAG_W];
  assign rd_data = ram_rdata[BYTES +: DATA_W];
  assign rd_par  = ram_rdata[BYTES-1:0];

  snoop_arb_par #(.BYTES(BYTES)) u_rd_par (.data(rd_data), .par(rd_par_calc));

  logic             line_hit, par_err, is_core_rd, is_snp;
  logic [SRC_W-1:0] err_src;

  always_comb begin
    is_core_rd = (s1_op == OP_LOAD) || (s1_op == OP_CAST);
    is_snp     = (s1_op == OP_SNOOP);
    line_hit   = s1_vld && ((s1_op == OP_CAST) || (rd_tag == s1_tag));
    par_err    = |(rd_par_calc ^ rd_par);
    err_src    = '0;
    err_src[SRC_HIT]  = (s1_op == OP_LOAD) && line_hit && par_err;
    err_src[SRC_CAST] = (s1_op == OP_CAST) && line_hit && par_err;
    err_src[SRC_PUSH] = is_snp && line_hit && par_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rvalid <= 1'b0;
      core_hit    <= 1'b0;
      core_rdata  <= '0;
      snp_rvalid  <= 1'b0;
      snp_hit     <= 1'b0;
      snp_rdata   <= '0;
      mchk        <= 1'b0;
      mchk_src    <= '0;
    end else begin
      core_rvalid <= is_core_rd;
      core_hit    <= is_core_rd && line_hit;
      core_rdata  <= (is_core_rd && line_hit) ? rd_data : '0;
      snp_rvalid  <= is_snp;
      snp_hit     <= is_snp && line_hit;
      snp_rdata   <= (is_snp && line_hit) ? rd_data : '0;
      mchk        <= |err_src;
      mchk_src    <= (mchk_src & ~mchk_clr) | err_src;
    end
  end

  // ---------------- assertions ----------------
  p_snoop_first_r1: assert property (@(posedge clk) disable iff (rst)
    snp_req |-> ##2 (snp_rvalid && !core_rvalid));

  p_core_result_r4: assert property (@(posedge clk) disable iff (rst)
    (core_gnt && core_op != CORE_STORE) |-> ##2 core_rvalid);

  p_store_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (core_gnt && core_op == CORE_STORE) |-> ##2 !core_rvalid);

  p_mchk_checked_r9: assert property (@(posedge clk) disable iff (rst)
    mchk |-> ((core_rvalid && core_hit) || (snp_rvalid && snp_hit)));

  p_mchk_status_r10: assert property (@(posedge clk) disable iff (rst)
    mchk |-> (mchk_src != '0));

endmodule

// File: tb/test_snoop_prio_array_arb.sv
module test_snoop_prio_array_arb;
  logic        clk = 1'b0;
  logic        rst;
  logic        core_req;
  logic [1:0]  core_op;
  logic [3:0]  core_idx;
  logic [7:0]  core_tag;
  logic [31:0] core_wdata;
  logic [3:0]  core_par_inj;
  logic        core_gnt, core_rvalid, core_hit;
  logic [31:0] core_rdata;
  logic        snp_req;
  logic [3:0]  snp_idx;
  logic [7:0]  snp_tag;
  logic        snp_rvalid, snp_hit;
  logic [31:0] snp_rdata;
  logic        mchk;
  logic [2:0]  mchk_src, mchk_clr;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  snoop_prio_array_arb i_snoop_prio_array_arb (
    .clk(clk), .rst(rst),
    .core_req(core_req), .core_op(core_op), .core_idx(core_idx),
    .core_tag(core_tag), .core_wdata(core_wdata), .core_par_inj(core_par_inj),
    .core_gnt(core_gnt), .core_rvalid(core_rvalid), .core_hit(core_hit),
    .core_rdata(core_rdata),
    .snp_req(snp_req), .snp_idx(snp_idx), .snp_tag(snp_tag),
    .snp_rvalid(snp_rvalid), .snp_hit(snp_hit), .snp_rdata(snp_rdata),
    .mchk(mchk), .mchk_src(mchk_src), .mchk_clr(mchk_clr)
  );

  // kind: 0 load, 1 store, 2 castout, 3 snoop
  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  idx;
    logic [7:0]  tag;
    logic [31:0] data;
    logic [3:0]  inj;
    logic        hit;
    logic        mc;
    logic [2:0]  src;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 4'd1, 8'h11, 32'hA5A50001, 4'h0, 1'b0, 1'b0, 3'b000},
    '{2'd0, 4'd1, 8'h11, 32'hA5A50001, 4'h0, 1'b1, 1'b0, 3'b000},
    '{2'd0, 4'd1, 8'h22, 32'h00000000, 4'h0, 1'b0, 1'b0, 3'b000},
    '{2'd3, 4'd1, 8'h11, 32'hA5A50001, 4'h0, 1'b1, 1'b0, 3'b000},
    '{2'd3, 4'd2, 8'h11, 32'h00000000, 4'h0, 1'b0, 1'b0, 3'b000},
    '{2'd1, 4'd2, 8'h33, 32'h12345678, 4'h4, 1'b0, 1'b0, 3'b000},
    '{2'd0, 4'd2, 8'h33, 32'h12345678, 4'h0, 1'b1, 1'b1, 3'b001},
    '{2'd0, 4'd2, 8'h44, 32'h00000000, 4'h0, 1'b0, 1'b0, 3'b000},
    '{2'd3, 4'd2, 8'h33, 32'h12345678, 4'h0, 1'b1, 1'b1, 3'b100},
    '{2'd2, 4'd2, 8'h99, 32'h12345678, 4'h0, 1'b1, 1'b1, 3'b010},
    '{2'd0, 4'd2, 8'h33, 32'h00000000, 4'h0, 1'b0, 1'b0, 3'b000},
    '{2'd2, 4'd2, 8'h33, 32'h00000000, 4'h0, 1'b0, 1'b0, 3'b000},
    '{2'd2, 4'd1, 8'h11, 32'hA5A50001, 4'h0, 1'b1, 1'b0, 3'b000},
    '{2'd3, 4'd1, 8'h11, 32'h00000000, 4'h0, 1'b0, 1'b0, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access, no contention; returns at the falling edge where its result is visible
  task automatic do_op(input logic [1:0] kind, input logic [3:0] idx, input logic [7:0] tag,
                       input logic [31:0] data, input logic [3:0] inj);
    @(negedge clk);
    if (kind == 2'd3) begin
      snp_req = 1'b1; snp_idx = idx; snp_tag = tag;
    end else begin
      core_req = 1'b1; core_op = kind; core_idx = idx; core_tag = tag;
      core_wdata = data; core_par_inj = inj;
    end
    @(negedge clk);
    core_req = 1'b0; snp_req = 1'b0; core_par_inj = '0;
    @(negedge clk);
  endtask

  task automatic clear_status();
    @(negedge clk); mchk_clr = 3'b111;
    @(negedge clk); mchk_clr = 3'b000;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; core_req = 0; core_op = 0; core_idx = 0; core_tag = 0;
    core_wdata = 0; core_par_inj = 0; snp_req = 0; snp_idx = 0; snp_tag = 0;
    mchk_clr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 core_rvalid after reset", {31'd0, core_rvalid}, 32'd0);
    chk("R12 snp_rvalid after reset", {31'd0, snp_rvalid}, 32'd0);
    chk("R12 mchk after reset", {31'd0, mchk}, 32'd0);
    chk("R12 mchk_src after reset", {29'd0, mchk_src}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      clear_status();
      do_op(v.kind, v.idx, v.tag, v.data, v.inj);
      if (v.kind == 2'd1) begin
        chk("R5 store gives no read result", {31'd0, core_rvalid}, 32'd0);
      end else if (v.kind == 2'd3) begin
        chk("R7 snoop result valid", {31'd0, snp_rvalid}, 32'd1);
        chk("R7 snoop hit", {31'd0, snp_hit}, {31'd0, v.hit});
        chk("R7 push data", snp_rdata, v.hit ? v.data : 32'd0);
      end else begin
        chk("R4 R6 core result valid", {31'd0, core_rvalid}, 32'd1);
        chk("R4 R6 core hit", {31'd0, core_hit}, {31'd0, v.hit});
        chk("R4 R6 core data", core_rdata, v.hit ? v.data : 32'd0);
      end
      chk("R8 R9 machine check", {31'd0, mchk}, {31'd0, v.mc});
      chk("R10 error source", {29'd0, mchk_src}, {29'd0, v.src});
      @(negedge clk);
      chk("R8 pulse lasts one cycle", {31'd0, mchk}, 32'd0);
    end

    // R1 R2: conflict, core deferred by one cycle
    do_op(2'd1, 4'd3, 8'h55, 32'hCAFEF00D, 4'h0);
    @(negedge clk);
    core_req = 1'b1; core_op = 2'd0; core_idx = 4'd3; core_tag = 8'h55;
    snp_req = 1'b1; snp_idx = 4'd1; snp_tag = 8'h11;
    #1 chk("R1 grant withheld on conflict", {31'd0, core_gnt}, 32'd0);
    @(negedge clk);
    snp_req = 1'b0;
    #1 chk("R2 grant in next cycle", {31'd0, core_gnt}, 32'd1);
    @(negedge clk);
    core_req = 1'b0;
    chk("R1 snoop result first", {31'd0, snp_rvalid}, 32'd1);
    chk("R1 no core result yet", {31'd0, core_rvalid}, 32'd0);
    @(negedge clk);
    chk("R2 deferred load result", {31'd0, core_rvalid & core_hit}, 32'd1);
    chk("R2 deferred load data", core_rdata, 32'hCAFEF00D);

    // R3: second snoop steals the replay cycle
    @(negedge clk);
    core_req = 1'b1; core_op = 2'd0; core_idx = 4'd3; core_tag = 8'h55;
    snp_req = 1'b1; snp_idx = 4'd3; snp_tag = 8'h55;
    #1 chk("R3 grant low with first snoop", {31'd0, core_gnt}, 32'd0);
    @(negedge clk);
    #1 chk("R3 grant low with second snoop", {31'd0, core_gnt}, 32'd0);
    @(negedge clk);
    snp_req = 1'b0;
    #1 chk("R3 grant after snoops end", {31'd0, core_gnt}, 32'd1);
    chk("R7 first snoop hit", {31'd0, snp_rvalid & snp_hit}, 32'd1);
    @(negedge clk);
    core_req = 1'b0;
    chk("R7 second snoop hit", {31'd0, snp_rvalid & snp_hit}, 32'd1);
    chk("R3 core not yet served", {31'd0, core_rvalid}, 32'd0);
    @(negedge clk);
    chk("R3 core result after two snoops", core_rdata, 32'hCAFEF00D);

    // R11: set wins over clear, clear is per bit
    do_op(2'd1, 4'd6, 8'h66, 32'h0BADBEEF, 4'b0001);
    clear_status();
    @(negedge clk);
    core_req = 1'b1; core_op = 2'd0; core_idx = 4'd6; core_tag = 8'h66;
    @(negedge clk);
    core_req = 1'b0; mchk_clr = 3'b001;
    @(negedge clk);
    mchk_clr = 3'b000;
    chk("R8 error on bad parity load", {31'd0, mchk}, 32'd1);
    chk("R11 set wins over clear", {29'd0, mchk_src}, 32'd1);
    @(negedge clk); mchk_clr = 3'b110;
    @(negedge clk); mchk_clr = 3'b000;
    chk("R11 other bits do not clear", {29'd0, mchk_src}, 32'd1);
    @(negedge clk); mchk_clr = 3'b001;
    @(negedge clk); mchk_clr = 3'b000;
    chk("R11 write one clears", {29'd0, mchk_src}, 32'd0);

    // R12: reset invalidates lines
    do_op(2'd1, 4'd5, 8'h77, 32'h5555AAAA, 4'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_op(2'd0, 4'd5, 8'h77, 32'd0, 4'h0);
    chk("R12 line invalid after reset", {31'd0, core_rvalid & ~core_hit}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule